// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C bus target that gives a bus master byte-wide read and write access to a small register bank outside the block. It takes SCL and SDA already synchronized to the system clock, detects the bus conditions from one-cycle edge history, and pulls SDA low through an open-drain enable. A strap input picks one of two adjacent 7-bit device addresses.

A write transaction carries the device address, then one byte that loads an internal register pointer, then any number of data bytes. Each data byte goes to the register at the pointer, and the pointer then advances. To read at random, the master writes the pointer, issues a repeated START and addresses the device for reading. The block then streams registers from the pointer onward and advances it after every byte the master acknowledges, until the master answers with a NAK. The pointer wraps from the top register back to 0. The bank sees a register address, the write data, a one-cycle write strobe and a combinational read-data return.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sda_oe_o` and `reg_we_o` are low and `reg_addr_o` is 0, so a read issued before any pointer write returns register 0.
- R2: A falling SDA while SCL is high is a START and moves the block to address reception. A rising SDA while SCL is high is a STOP and returns it to idle. A repeated START restarts address reception.
- R3: The first byte after a START carries the address in bits 7..1 (MSB first on the wire) and the direction in bit 0 (0 = write, 1 = read). The address matches 7'h1C when `addr_sel_i` is 0 and 7'h1D when it is 1.
- R4: On a match, and after every received data byte, the block holds SDA low through the ninth SCL clock, from the falling edge that ends bit 8 until the falling edge that ends the ninth clock.
- R5: After a non-matching address the block never drives SDA, writes nothing and leaves the pointer unchanged until the next START or STOP.
- R6: In a write, the first data byte loads the pointer from its low bits. Each later byte produces one single-cycle `reg_we_o` pulse with `reg_addr_o` equal to the pointer, and the pointer then advances by 1, wrapping from 15 to 0.
- R7: A read returns the register at the pointer, MSB first, with each bit changed on SDA only while SCL is low.
- R8: During a read the pointer advances after every byte the master acknowledges (wrapping from 15 to 0). After a NAK the block releases SDA and stays silent until STOP or START.
- R9: A START or STOP in the middle of a byte discards the partial byte. No write happens and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_sel_i | input | 1 | Strap: selects the device address LSB |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr_o | output | AW | Register pointer / bank address |
| reg_wdata_o | output | 8 | Write data to the bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data from the bank at `reg_addr_o` |

## Verification
The assertions check on every cycle that SDA drive only changes after a cycle with SCL low, that a START lands the block in address reception with SDA released, and that a STOP always ends in idle. They also check that every write strobe comes with the ACK drive and lasts one cycle, and that the block stays silent while it ignores traffic. Only the bench's bus scenarios can show the address decode under both strap values, the pointer load and its wrap in both directions, and the contents of the data streams in bursts. The same holds for the release after a NAK and for the discarding of bytes cut off by a START or STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= ptr_q + AW'(1); // natural wrap
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic              ptr_load_o,
  output logic              ptr_inc_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output tgt_state_e        state_o
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  tgt_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              ack_drv_q, tx_act_q, rw_q, ptr_phase_q, mack_q;
  logic              we_q, ld_q, rinc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ack_drv_q   <= 1'b0;
      tx_act_q    <= 1'b0;
      rw_q        <= 1'b0;
      ptr_phase_q <= 1'b0;
      mack_q      <= 1'b0;
      we_q        <= 1'b0;
      ld_q        <= 1'b0;
      rinc_q      <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      ld_q   <= 1'b0;
      rinc_q <= 1'b0;
      if (stop_i) begin
        state_q   <= ST_IDLE;
        ack_drv_q <= 1'b0;
        tx_act_q  <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        ack_drv_q <= 1'b0;
        tx_act_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && cnt_q != FULL) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + CW'(1);
            end
            if (scl_fall_i && cnt_q == FULL) begin
              if (state_q == ST_ADDR) begin
                if (rx_q[7:1] == dev_addr_i) begin
                  ack_drv_q <= 1'b1;
                  rw_q      <= rx_q[0];
                  state_q   <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else begin
                ack_drv_q <= 1'b1;
                state_q   <= ST_WR_ACK;
                if (ptr_phase_q) begin
                  ld_q        <= 1'b1;
                  ptr_phase_q <= 1'b0;
                end else begin
                  we_q <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            ack_drv_q <= 1'b0;
            cnt_q     <= '0;
            if (rw_q) begin
              tx_q     <= rdata_i;
              tx_act_q <= 1'b1;
              state_q  <= ST_RD;
            end else begin
              ptr_phase_q <= 1'b1;
              state_q     <= ST_WR;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            ack_drv_q <= 1'b0;
            cnt_q     <= '0;
            state_q   <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise_i) cnt_q <= cnt_q + CW'(1);
            if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                tx_act_q <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
              rinc_q <= ~sda_i; // pointer settles before the next fall
            end
            if (scl_fall_i) begin
              if (mack_q) begin
                cnt_q    <= '0;
                tx_q     <= rdata_i;
                tx_act_q <= 1'b1;
                state_q  <= ST_RD;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = ack_drv_q | (tx_act_q & ~tx_q[BYTE_W-1]);
  assign we_o       = we_q;
  assign ptr_load_o = ld_q;
  assign ptr_inc_o  = we_q | rinc_q;
  assign rx_byte_o  = rx_q;
  assign state_o    = state_q;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter logic [5:0]  DEV_ADDR_HI = 6'b001110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_sel_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic              start_w, stop_w, rise_w, fall_w;
  logic              ld_w, inc_w;
  logic [BYTE_W-1:0] rx_byte_w;
  tgt_state_e        fsm_state;

  i2c_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  i2c_target_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (rise_w),
    .scl_fall_i (fall_w),
    .sda_i      (sda_i),
    .dev_addr_i ({DEV_ADDR_HI, addr_sel_i}),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .we_o       (reg_we_o),
    .ptr_load_o (ld_w),
    .ptr_inc_o  (inc_w),
    .rx_byte_o  (rx_byte_w),
    .state_o    (fsm_state)
  );

  i2c_reg_ptr #(.AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_w),
    .load_val_i (rx_byte_w[AW-1:0]),
    .inc_i      (inc_w),
    .ptr_o      (reg_addr_o)
  );

  assign reg_wdata_o = rx_byte_w;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input logic       start_i,
  input logic       stop_i,
  input tgt_state_e state_i
);
  a_r2_start_to_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> state_i == ST_ADDR && !sda_oe_o);

  a_r2_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_i == ST_IDLE);

  a_r4_strobe_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> sda_oe_o);

  a_r6_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r7_launch_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_i));

  a_r5_silent_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IGNORE |-> !sda_oe_o && !reg_we_o);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .reg_we_o (reg_we_o),
  .start_i  (start_w),
  .stop_i   (stop_w),
  .state_i  (fsm_state)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_we;

  logic [7:0] bank [16];
  logic [7:0] exp_bank [16];
  logic [11:0] exp_q [$];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_addr];

  i2c_reg_target u_i2c_reg_target (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_sel_i  (addr_sel),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the next expected write
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        chk("R5/R9 unexpected write", {20'h0, reg_addr, reg_wdata}, 32'hFFFF_FFFF);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk("R6 write addr/data", {20'h0, reg_addr, reg_wdata}, {20'h0, e});
      end
      bank[reg_addr] = reg_wdata;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; scl = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0; tick(1);
  endtask

  task automatic m_rstart;
    sda_m = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0; tick(1);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic m_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(1);
    end
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    m_bits(b, 8);
    sda_m = 1'b1; tick(H);
    scl = 1'b1; tick(H/2);
    ack = ~sda_bus; tick(H/2);
    scl = 1'b0; tick(1);
  endtask

  task automatic m_recv(input logic nak, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      scl = 1'b1; tick(H/2);
      b = {b[6:0], sda_bus}; tick(H/2);
      scl = 1'b0;
    end
    tick(1);
    sda_m = nak; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(1);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [3:0] ptr, input int n,
                          input logic [7:0] base, input string req);
    logic ack;
    logic [3:0] a;
    m_start;
    m_send({dev, 1'b0}, ack); chk({req, " R4 addr ack"}, ack, 1);
    m_send({4'h0, ptr}, ack); chk({req, " R6 ptr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      a = ptr + 4'(i);
      exp_q.push_back({a, base + 8'(i)});
      exp_bank[a] = base + 8'(i);
      m_send(base + 8'(i), ack); chk({req, " R4 data ack"}, ack, 1);
    end
    m_stop;
    chk({req, " R2 released after stop"}, sda_oe, 0);
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [3:0] ptr, input int n,
                         input string req);
    logic ack;
    logic [7:0] d;
    m_start;
    m_send({dev, 1'b0}, ack); chk({req, " R3 addr ack"}, ack, 1);
    m_send({4'h0, ptr}, ack); chk({req, " R6 ptr ack"}, ack, 1);
    m_rstart;
    m_send({dev, 1'b1}, ack); chk({req, " R2 rstart read ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      m_recv(i == n - 1, d);
      chk({req, " R7 read data"}, d, exp_bank[ptr + 4'(i)]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      bank[i] = 8'h40 + 8'(i);
      exp_bank[i] = 8'h40 + 8'(i);
    end
    tick(3);
    chk("R1 sda_oe reset", sda_oe, 0);
    chk("R1 we reset", reg_we, 0);
    chk("R1 pointer reset", reg_addr, 0);
    rst_n = 1'b1;
    tick(4);

    // R1/R3: read without pointer setup, strap high -> 0x1D
    m_start;
    m_send({7'h1D, 1'b1}, ack); chk("R3 0x1D read ack", ack, 1);
    m_recv(1'b1, d); chk("R1 read reg0", d, 8'h40);
    m_stop;

    // R6: burst write from 3
    do_write(7'h1D, 4'd3, 3, 8'h11, "R6 burst");
    chk("R6 pointer after burst", reg_addr, 6);

    // R7/R8: random read with burst
    do_read(7'h1D, 4'd4, 3, "R8 burst read");
    m_stop;
    chk("R8 pointer after 2 acks", reg_addr, 6);

    // R6 wrap on write
    do_write(7'h1D, 4'd15, 2, 8'h55, "R6 wrap");
    chk("R6 pointer wrapped", reg_addr, 1);

    // R8 wrap on read, then release after NAK
    do_read(7'h1D, 4'd14, 4, "R8 wrap read");
    m_recv(1'b1, d); chk("R8 released after NAK", d, 8'hFF);
    m_stop;
    chk("R8 pointer after wrap read", reg_addr, 1);

    // R5: non-matching address under strap high
    m_start;
    m_send({7'h1C, 1'b0}, ack); chk("R5 no ack wrong addr", ack, 0);
    m_send(8'h00, ack); chk("R5 no ack byte1", ack, 0);
    m_send(8'h99, ack); chk("R5 no ack byte2", ack, 0);
    chk("R5 pointer untouched", reg_addr, 1);
    m_stop;

    // R3: strap low
    addr_sel = 1'b0;
    m_start;
    m_send({7'h1D, 1'b0}, ack); chk("R3 0x1D rejected strap low", ack, 0);
    m_stop;
    do_write(7'h1C, 4'd7, 1, 8'h77, "R3 strap low write");
    chk("R6 pointer after single", reg_addr, 8);

    // R9: repeated START mid data byte
    m_start;
    m_send({7'h1C, 1'b0}, ack); chk("R9 addr ack", ack, 1);
    m_send(8'h09, ack); chk("R9 ptr ack", ack, 1);
    m_bits(8'hF0, 4);
    m_rstart;
    m_send({7'h1C, 1'b1}, ack); chk("R9 rstart read ack", ack, 1);
    chk("R9 pointer kept after abort", reg_addr, 9);
    m_recv(1'b1, d); chk("R9 read after abort", d, exp_bank[9]);
    m_stop;

    // R9: STOP mid data byte
    m_start;
    m_send({7'h1C, 1'b0}, ack); chk("R9 addr ack 2", ack, 1);
    m_send(8'h02, ack); chk("R9 ptr ack 2", ack, 1);
    m_bits(8'hAA, 5);
    m_stop;
    chk("R9 pointer after stop abort", reg_addr, 2);
    chk("R2 idle released", sda_oe, 0);
    m_start;
    m_send({7'h1C, 1'b1}, ack); chk("R3 read ack strap low", ack, 1);
    m_recv(1'b1, d); chk("R7 read reg2", d, exp_bank[2]);
    m_stop;

    tick(4);
    chk("R6 all writes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule